// File: doc/BRIEF.md
# PCI Function Command and Status Registers

This block holds the 16-bit command register and the 16-bit device status register of one PCI function inside a bridge. Both registers sit in one configuration dword. Byte 0 and byte 1 of that dword are the command register, and bytes 2 and 3 are the status register. Configuration reads and writes reach the block as simple strobes with a dword index and per-byte enables. A read returns the whole dword one cycle after the strobe.

Only two command bits can be written. The first enables recognition of a Shutdown special cycle. The second enables the system-error request. The remaining command bits read at fixed values. Four status bits are sticky flags: the bus-interface logic sets them through event strobes, and software clears them by writing a 1. The block also drives two one-cycle pulses. One requests SERR# when a delayed-transaction timeout occurs with both enables set. The other reports a recognised Shutdown special cycle.

Top module: `pci_cmd_sts`

## Requirements
- R1: After reset, a read at dword index 1 returns 0x02800007, meaning status 0x0280 and command 0x0007.
- R2: Command bits 0, 1 and 2 always read 1. Command bits 4, 5, 6, 7, 9 and 15:10 always read 0. Writes to any of these bits have no effect.
- R3: Command bit 3 is the special-cycle enable, written through byte lane 0. When it is 1, a `specialShutdown` strobe produces one cycle of `shutdownPulse` on the next cycle. When it is 0, the strobe produces no pulse.
- R4: Command bit 8 is the SERR# enable, written through byte lane 1. A `dtTimeout` strobe produces one cycle of `serrReq` on the next cycle, but only when bit 8 is 1 and `extSerrAllow` is 1.
- R5: Status bit 14 is set on the same edge at which `serrReq` goes high.
- R6: Status bit 13 is set by `evtMasterAbort`, bit 12 by `evtRecvTargetAbort` and bit 11 by `evtSigTargetAbort`. Each bit is visible from the next cycle onward.
- R7: Status bits 14:11 are cleared by writing 1 to them through byte lane 3. Writing 0 to one of these bits leaves it unchanged.
- R8: When an event strobe and a write-1 clear of the same status bit fall in the same cycle, the bit ends up set.
- R9: `cfgRdEn` with a matching index raises `cfgRdValid` on the next cycle. In that cycle `cfgRdData` holds the status register in bits 31:16 and the command register in bits 15:0. In every other cycle `cfgRdValid` and `cfgRdData` are 0.
- R10: A write changes only the byte lanes whose enable bit is set. A write at any index other than 1 changes nothing.
- R11: Status bit 15 reads 0, bits 10:9 read 01, bit 7 reads 1 and every other status bit outside 14:11 reads 0. Writes to these bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgRdEn | input | 1 | Configuration read strobe |
| cfgAddr | input | ADDR_W | Configuration dword index |
| cfgByteEn | input | 4 | Byte-lane enables for writes |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data: status in bits 31:16, command in bits 15:0 |
| cfgRdValid | output | 1 | Read data valid, one cycle after a matching read |
| specialShutdown | input | 1 | Decoded Shutdown special cycle strobe |
| dtTimeout | input | 1 | Delayed-transaction timeout strobe |
| extSerrAllow | input | 1 | External system-error permission level |
| evtMasterAbort | input | 1 | The function, acting as master, performed a master-abort |
| evtRecvTargetAbort | input | 1 | The function, acting as master, received a target-abort |
| evtSigTargetAbort | input | 1 | The function, acting as target, signalled a target-abort |
| shutdownPulse | output | 1 | One-cycle pulse for a recognised Shutdown cycle |
| serrReq | output | 1 | One-cycle SERR# request |

## Verification
The hardest situation to reach is a sticky status bit that is set and cleared in the same cycle. This needs an event strobe to coincide exactly with a byte-lane-3 write carrying a 1 in that bit. The bench drives both in one cycle, from one task, on purpose. It then repeats such collisions at random in a long mixed phase, where a behavioural model predicts every output cycle by cycle. The SERR# path needs three conditions to line up: the enable bit has been written, the external permission is high and a timeout arrives. The directed steps visit each combination of these conditions in turn.

// File: rtl/pci_cs_pkg.sv
package pci_cs_pkg;
  localparam int DATA_W   = 32;
  localparam int BE_W     = DATA_W / 8;
  localparam int CMD_SCE  = 3;
  localparam int CMD_SERR = 8;
  localparam int STICKY_LO = 11;
  localparam int STICKY_N  = 4;

  typedef struct packed {
    logic rdHit;
    logic wrLane0;
    logic wrLane1;
    logic wrLane3;
    logic serrFire;
    logic shutFire;
  } csStrobes_t;
endpackage

// File: rtl/pci_cs_ctrl.sv
module pci_cs_ctrl
  import pci_cs_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int REG_IDX = 1
) (
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [BE_W-1:0]   cfgByteEn,
  input  logic              specialShutdown,
  input  logic              dtTimeout,
  input  logic              extSerrAllow,
  input  logic              sceBit,
  input  logic              serrEnBit,
  output csStrobes_t        strb
);
  localparam logic [ADDR_W-1:0] MY_IDX = ADDR_W'(REG_IDX);

  logic hit;
  logic wrHit;

  always_comb begin
    hit           = (cfgAddr == MY_IDX);
    wrHit         = cfgWrEn && hit;
    strb.rdHit    = cfgRdEn && hit;
    strb.wrLane0  = wrHit && cfgByteEn[0];
    strb.wrLane1  = wrHit && cfgByteEn[1];
    strb.wrLane3  = wrHit && cfgByteEn[3];
    strb.serrFire = dtTimeout && serrEnBit && extSerrAllow;
    strb.shutFire = specialShutdown && sceBit;
  end
endmodule

// File: rtl/pci_cs_dp.sv
module pci_cs_dp
  import pci_cs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  csStrobes_t        strb,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              evtMasterAbort,
  input  logic              evtRecvTargetAbort,
  input  logic              evtSigTargetAbort,
  output logic              sceBit,
  output logic              serrEnBit,
  output logic [DATA_W-1:0] cfgRdData,
  output logic              cfgRdValid,
  output logic              shutdownPulse,
  output logic              serrReq
);
  localparam int HALF = DATA_W / 2;

  logic [STICKY_N-1:0] sticky;
  logic [STICKY_N-1:0] setVec;
  logic [HALF-1:0]     cmdView;
  logic [HALF-1:0]     stsView;

  // order: bit 11 sig target abort, 12 recv target abort, 13 master abort, 14 serr
  assign setVec = {strb.serrFire, evtMasterAbort, evtRecvTargetAbort, evtSigTargetAbort};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sceBit    <= 1'b0;
      serrEnBit <= 1'b0;
    end else begin
      if (strb.wrLane0) sceBit    <= cfgWrData[CMD_SCE];
      if (strb.wrLane1) serrEnBit <= cfgWrData[CMD_SERR];
    end
  end

  for (genvar i = 0; i < STICKY_N; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        sticky[i] <= 1'b0;
      else if (setVec[i])
        sticky[i] <= 1'b1;
      else if (strb.wrLane3 && cfgWrData[HALF + STICKY_LO + i])
        sticky[i] <= 1'b0;
    end
  end

  always_comb begin
    cmdView = '0;
    cmdView[2:0]      = 3'b111;
    cmdView[CMD_SCE]  = sceBit;
    cmdView[CMD_SERR] = serrEnBit;
    stsView = '0;
    stsView[7]        = 1'b1;
    stsView[10:9]     = 2'b01;
    stsView[STICKY_LO +: STICKY_N] = sticky;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgRdData     <= '0;
      cfgRdValid    <= 1'b0;
      shutdownPulse <= 1'b0;
      serrReq       <= 1'b0;
    end else begin
      cfgRdValid    <= strb.rdHit;
      cfgRdData     <= strb.rdHit ? {stsView, cmdView} : '0;
      shutdownPulse <= strb.shutFire;
      serrReq       <= strb.serrFire;
    end
  end
endmodule

// File: rtl/pci_cmd_sts.sv
module pci_cmd_sts
  import pci_cs_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int REG_IDX = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [3:0]        cfgByteEn,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  output logic              cfgRdValid,
  input  logic              specialShutdown,
  input  logic              dtTimeout,
  input  logic              extSerrAllow,
  input  logic              evtMasterAbort,
  input  logic              evtRecvTargetAbort,
  input  logic              evtSigTargetAbort,
  output logic              shutdownPulse,
  output logic              serrReq
);
  csStrobes_t strb;
  logic       sceBit;
  logic       serrEnBit;

  pci_cs_ctrl #(.ADDR_W(ADDR_W), .REG_IDX(REG_IDX)) ctrl_i (
    .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn),
    .specialShutdown(specialShutdown), .dtTimeout(dtTimeout), .extSerrAllow(extSerrAllow),
    .sceBit(sceBit), .serrEnBit(serrEnBit), .strb(strb)
  );

  pci_cs_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWrData(cfgWrData),
    .evtMasterAbort(evtMasterAbort), .evtRecvTargetAbort(evtRecvTargetAbort),
    .evtSigTargetAbort(evtSigTargetAbort), .sceBit(sceBit), .serrEnBit(serrEnBit),
    .cfgRdData(cfgRdData), .cfgRdValid(cfgRdValid),
    .shutdownPulse(shutdownPulse), .serrReq(serrReq)
  );
endmodule

// File: rtl/pci_cmd_sts_chk.sv
module pci_cmd_sts_chk #(
  parameter int ADDR_W  = 6,
  parameter int REG_IDX = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgRdEn,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [31:0]       cfgRdData,
  input logic              cfgRdValid,
  input logic              specialShutdown,
  input logic              dtTimeout,
  input logic              extSerrAllow,
  input logic              shutdownPulse,
  input logic              serrReq
);
  localparam logic [ADDR_W-1:0] MY_IDX = ADDR_W'(REG_IDX);

  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdEn && cfgAddr == MY_IDX) |=> cfgRdValid);  // R9
  AST_CMD_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdValid |-> (cfgRdData[2:0] == 3'b111 && cfgRdData[7:4] == 4'h0 && cfgRdData[15:9] == 7'h0));  // R2
  AST_STS_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdValid |-> (cfgRdData[31] == 1'b0 && cfgRdData[26:25] == 2'b01 && cfgRdData[23] == 1'b1));  // R11
  AST_SERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    serrReq |-> $past(dtTimeout && extSerrAllow));  // R4
  AST_SHUT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    shutdownPulse |-> $past(specialShutdown));  // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdValid |-> cfgRdData == 32'h0);  // R9
endmodule

bind pci_cmd_sts pci_cmd_sts_chk #(.ADDR_W(ADDR_W), .REG_IDX(REG_IDX)) chk_i (
  .clk(clk), .rstN(rstN), .cfgRdEn(cfgRdEn), .cfgAddr(cfgAddr),
  .cfgRdData(cfgRdData), .cfgRdValid(cfgRdValid), .specialShutdown(specialShutdown),
  .dtTimeout(dtTimeout), .extSerrAllow(extSerrAllow),
  .shutdownPulse(shutdownPulse), .serrReq(serrReq)
);

// File: tb/pci_cmd_sts_tb.sv
module pci_cmd_sts_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 0, cfgRdEn = 0;
  logic [5:0]  cfgAddr = 0;
  logic [3:0]  cfgByteEn = 0;
  logic [31:0] cfgWrData = 0;
  logic [31:0] cfgRdData;
  logic        cfgRdValid;
  logic        specialShutdown = 0, dtTimeout = 0, extSerrAllow = 0;
  logic        evtMasterAbort = 0, evtRecvTargetAbort = 0, evtSigTargetAbort = 0;
  logic        shutdownPulse, serrReq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pci_cmd_sts dut_i (.*);

  // behavioural reference model
  bit        mSce, mSerrEn;
  bit [3:0]  mSticky;
  bit        mRdValid, mSerr, mShut;
  bit [31:0] mRdData;

  function automatic bit [31:0] modelDword();
    int cmd, sts;
    cmd = 7 + (mSce ? 8 : 0) + (mSerrEn ? 256 : 0);
    sts = 'h0280 + mSticky * 2048;
    return 32'(sts * 65536 + cmd);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSce = 0; mSerrEn = 0; mSticky = 0;
      mRdValid = 0; mRdData = 0; mSerr = 0; mShut = 0;
    end else begin
      bit hit, fire;
      bit [3:0] ev;
      hit = (cfgAddr == 6'd1);
      fire = dtTimeout && mSerrEn && extSerrAllow;
      mRdValid = cfgRdEn && hit;
      mRdData  = mRdValid ? modelDword() : 32'h0;
      mShut    = specialShutdown && mSce;
      mSerr    = fire;
      ev = {fire, evtMasterAbort, evtRecvTargetAbort, evtSigTargetAbort};
      for (int i = 0; i < 4; i++) begin
        if (cfgWrEn && hit && cfgByteEn[3] && cfgWrData[27 + i]) mSticky[i] = 0;
        if (ev[i]) mSticky[i] = 1;
      end
      if (cfgWrEn && hit && cfgByteEn[0]) mSce = cfgWrData[3];
      if (cfgWrEn && hit && cfgByteEn[1]) mSerrEn = cfgWrData[8];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    check("R9 rdValid model", {31'h0, cfgRdValid}, {31'h0, mRdValid});
    check("R9 rdData model", cfgRdData, mRdData);
    check("R4 serrReq model", {31'h0, serrReq}, {31'h0, mSerr});
    check("R3 shutdownPulse model", {31'h0, shutdownPulse}, {31'h0, mShut});
  end

  task automatic idle();
    cfgWrEn = 0; cfgRdEn = 0; specialShutdown = 0; dtTimeout = 0;
    evtMasterAbort = 0; evtRecvTargetAbort = 0; evtSigTargetAbort = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    cfgWrEn = 1; cfgAddr = a; cfgByteEn = be; cfgWrData = d; step();
  endtask

  task automatic rdCheck(input string tag, input logic [31:0] exp);
    cfgRdEn = 1; cfgAddr = 6'd1; step();
    check(tag, cfgRdData, exp);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 no read valid after reset", {31'h0, cfgRdValid}, 32'h0);
    rdCheck("R1 reset dword", 32'h0280_0007);
    wr(6'd1, 4'hF, 32'hFFFF_FFFF);
    rdCheck("R2 R11 fixed bits after all-ones write", 32'h0280_010F);
    wr(6'd1, 4'hF, 32'h0);
    rdCheck("R2 fixed bits after zero write", 32'h0280_0007);
    wr(6'd1, 4'h1, 32'hFFFF_FFFF);
    rdCheck("R10 lane0 only", 32'h0280_000F);
    wr(6'd1, 4'h2, 32'h0000_0100);
    rdCheck("R10 lane1 only", 32'h0280_010F);
    wr(6'd2, 4'hF, 32'h0);
    rdCheck("R10 other index ignored", 32'h0280_010F);
    // shutdown with enable set
    specialShutdown = 1; @(posedge clk); @(negedge clk); idle();
    check("R3 pulse after shutdown", {31'h0, shutdownPulse}, 32'h1);
    step();
    check("R3 pulse is one cycle", {31'h0, shutdownPulse}, 32'h0);
    // timeout with external permission low
    dtTimeout = 1; extSerrAllow = 0; step();
    check("R4 no serr when external low", {31'h0, serrReq}, 32'h0);
    extSerrAllow = 1; dtTimeout = 1; step();
    check("R4 serr pulse", {31'h0, serrReq}, 32'h1);
    rdCheck("R5 status bit 14 set", 32'h4280_010F);
    evtMasterAbort = 1; evtRecvTargetAbort = 1; evtSigTargetAbort = 1; step();
    rdCheck("R6 abort bits set", 32'h7A80_010F);
    wr(6'd1, 4'h8, 32'h4000_0000);
    rdCheck("R7 write-1 clears bit 14", 32'h3A80_010F);
    wr(6'd1, 4'h4, 32'hFFFF_0000);
    rdCheck("R7 lane3 disabled leaves bits", 32'h3A80_010F);
    wr(6'd1, 4'h8, 32'h0);
    rdCheck("R7 write-0 leaves bits", 32'h3A80_010F);
    cfgWrEn = 1; cfgAddr = 6'd1; cfgByteEn = 4'h8; cfgWrData = 32'h3800_0000;
    evtMasterAbort = 1; step();
    rdCheck("R8 set wins over clear", 32'h2280_010F);
    wr(6'd1, 4'h3, 32'h0);
    specialShutdown = 1; dtTimeout = 1; step();
    check("R3 no pulse when disabled", {31'h0, shutdownPulse}, 32'h0);
    check("R4 no serr when disabled", {31'h0, serrReq}, 32'h0);
    rdCheck("R11 status after sequence", 32'h2280_0007);
    // mixed random phase checked by the model
    for (int n = 0; n < 3000; n++) begin
      cfgWrEn = ($urandom_range(3) == 0);
      cfgRdEn = ($urandom_range(1) == 0);
      cfgAddr = ($urandom_range(5) == 0) ? 6'($urandom_range(63)) : 6'd1;
      cfgByteEn = 4'($urandom);
      cfgWrData = $urandom;
      specialShutdown = ($urandom_range(3) == 0);
      dtTimeout = ($urandom_range(3) == 0);
      extSerrAllow = $urandom_range(1) == 1;
      evtMasterAbort = ($urandom_range(7) == 0);
      evtRecvTargetAbort = ($urandom_range(7) == 0);
      evtSigTargetAbort = ($urandom_range(7) == 0);
      @(posedge clk); @(negedge clk);
    end
    idle();
    step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule